// File: doc/BRIEF.md
# 10 Mb/s heartbeat and jabber lockout controller

This block sits beside a 10 Mb/s twisted-pair transmitter and watches the transmit enable that the MAC drives. When a frame ends, it waits a short gap and then raises the collision output for a brief pulse. This pulse is the heartbeat that tells the MAC that the transmit path and the collision path are both alive.

The block also guards the line against a runaway transmitter. If transmit enable stays high longer than an assert timeout, the block locks the transmitter out. It reports the lockout on a status flag and holds the collision output high. The lockout ends only after transmit enable has stayed low for a release timeout that is much longer than the assert timeout. Both functions act only while the link runs at 10 Mb/s.

All time constants are parameters counted in clock cycles, so a simulation can use short windows. The defaults assume a 25 MHz clock: a 20 ms assert timeout, a 250 ms release timeout, and a 1 µs gap before a 1 µs heartbeat pulse. The block has no data stream, so every pin is a plain level with no handshake.

Top module: `sqe_jabber_ctrl`

## Requirements
- R1: While rst_n is low, col, tx_disable and jabber are low, and any lockout or pending pulse in progress is dropped.
- R2: When tx_en is first sampled low after being sampled high, with no lockout active, col goes high SQE_DELAY cycles after that first low sample and stays high for exactly SQE_WIDTH cycles.
- R3: A tx_en burst of up to and including JAB_LIMIT consecutive high samples leaves tx_disable and jabber low.
- R4: On the (JAB_LIMIT+1)-th consecutive high sample of tx_en, tx_disable, jabber and col go high after that clock edge.
- R5: In lockout, the outputs clear after the (REL_LIMIT+1)-th consecutive low sample of tx_en, and not earlier.
- R6: Any high sample of tx_en during lockout restarts the release count from zero.
- R7: A frame whose end falls inside a lockout produces no heartbeat pulse, neither during the lockout nor after its release.
- R8: While speed_10 is low, col and tx_disable are low after the next edge. All counters and any lockout are cleared, so no pulse or lockout carries over when speed_10 returns high.
- R9: jabber always equals tx_disable, and col is high whenever tx_disable is high.
- R10: A new end of frame while a heartbeat is still waiting restarts the SQE_DELAY gap from the new end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_10 | input | 1 | High when the link runs at 10 Mb/s; low disables and clears the block |
| tx_en | input | 1 | Transmit enable from the MAC |
| col | output | 1 | Collision indication: heartbeat pulse or lockout level |
| tx_disable | output | 1 | High while the transmitter is locked out |
| jabber | output | 1 | Lockout status flag |

## Verification
The bench probes the exact edges of both timeouts. It sends a burst of exactly JAB_LIMIT high samples and then one more, so an off-by-one trip point shows up as an early or missing lockout. The same is done with the release window. Further cases target the failures that are easy to miss. A release count that a mid-recovery high sample does not reset would release too early. A stale falling edge kept across a lockout would emit a heartbeat after release. A design that ignores a second frame end would start its pulse during the next frame. The bench also drops speed_10 in the middle of a lockout and checks that the outputs fall at once and that nothing is left over when the speed returns.

// File: rtl/sqe_jab_pkg.sv
package sqe_jab_pkg;
  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/heartbeat_gen.sv
module heartbeat_gen
  import sqe_jab_pkg::*;
#(
  parameter int unsigned GAP_CYC   = 25,
  parameter int unsigned WIDTH_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inhibit,
  input  logic tx_en,
  output logic pulse
);
  localparam int unsigned CW      = $clog2(max2(GAP_CYC, WIDTH_CYC) + 1);
  localparam logic [CW-1:0] GAP_TOP = CW'(GAP_CYC);
  localparam logic [CW-1:0] WID_TOP = CW'(WIDTH_CYC);
  localparam logic [CW-1:0] ONE     = CW'(1);

  hb_state_t     state_q;
  logic [CW-1:0] cnt_q;
  logic          tx_prev_q;
  logic          frame_end;

  assign frame_end = tx_prev_q & ~tx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= HB_IDLE;
      cnt_q     <= '0;
      tx_prev_q <= 1'b0;
    end else if (inhibit) begin
      state_q   <= HB_IDLE;
      cnt_q     <= '0;
      tx_prev_q <= 1'b0;
    end else begin
      tx_prev_q <= tx_en;
      if (frame_end) begin
        // a fresh end of frame always restarts the gap
        state_q <= HB_WAIT;
        cnt_q   <= ONE;
      end else begin
        unique case (state_q)
          HB_WAIT: begin
            if (cnt_q == GAP_TOP) begin
              state_q <= HB_PULSE;
              cnt_q   <= ONE;
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end
          HB_PULSE: begin
            if (cnt_q == WID_TOP) begin
              state_q <= HB_IDLE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end
          default: begin
            state_q <= HB_IDLE;
            cnt_q   <= '0;
          end
        endcase
      end
    end
  end

  assign pulse = (state_q == HB_PULSE);
endmodule

// File: rtl/jabber_guard.sv
module jabber_guard #(
  parameter int unsigned TRIP_CYC    = 500_000,
  parameter int unsigned RELEASE_CYC = 6_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tx_en,
  output logic locked
);
  localparam int unsigned HW = $clog2(TRIP_CYC + 1);
  localparam int unsigned LW = $clog2(RELEASE_CYC + 1);
  localparam logic [HW-1:0] TRIP_TOP = HW'(TRIP_CYC);
  localparam logic [LW-1:0] REL_TOP  = LW'(RELEASE_CYC);

  logic [HW-1:0] hi_cnt_q;
  logic [LW-1:0] lo_cnt_q;
  logic          locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q <= '0;
      lo_cnt_q <= '0;
      locked_q <= 1'b0;
    end else if (!enable) begin
      hi_cnt_q <= '0;
      lo_cnt_q <= '0;
      locked_q <= 1'b0;
    end else if (!locked_q) begin
      lo_cnt_q <= '0;
      if (!tx_en) begin
        hi_cnt_q <= '0;
      end else if (hi_cnt_q == TRIP_TOP) begin
        locked_q <= 1'b1;
        hi_cnt_q <= '0;
      end else begin
        hi_cnt_q <= hi_cnt_q + HW'(1);
      end
    end else begin
      hi_cnt_q <= '0;
      if (tx_en) begin
        lo_cnt_q <= '0;
      end else if (lo_cnt_q == REL_TOP) begin
        locked_q <= 1'b0;
        lo_cnt_q <= '0;
      end else begin
        lo_cnt_q <= lo_cnt_q + LW'(1);
      end
    end
  end

  assign locked = locked_q;
endmodule

// File: rtl/sqe_jabber_ctrl.sv
module sqe_jabber_ctrl #(
  parameter int unsigned JAB_LIMIT  = 500_000,
  parameter int unsigned REL_LIMIT  = 6_250_000,
  parameter int unsigned SQE_DELAY  = 25,
  parameter int unsigned SQE_WIDTH  = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed_10,
  input  logic tx_en,
  output logic col,
  output logic tx_disable,
  output logic jabber
);
  logic locked;
  logic hb_pulse;

  jabber_guard #(
    .TRIP_CYC    (JAB_LIMIT),
    .RELEASE_CYC (REL_LIMIT)
  ) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (speed_10),
    .tx_en  (tx_en),
    .locked (locked)
  );

  heartbeat_gen #(
    .GAP_CYC   (SQE_DELAY),
    .WIDTH_CYC (SQE_WIDTH)
  ) u_hb (
    .clk     (clk),
    .rst_n   (rst_n),
    .inhibit (locked | ~speed_10),
    .tx_en   (tx_en),
    .pulse   (hb_pulse)
  );

  assign col        = locked | hb_pulse;
  assign tx_disable = locked;
  assign jabber     = locked;
endmodule

// File: rtl/sqe_jabber_ctrl_chk.sv
module sqe_jabber_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic speed_10,
  input logic tx_en,
  input logic col,
  input logic tx_disable,
  input logic jabber
);
  // R9: status flag tracks the lockout
  a_r9_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
    jabber == tx_disable);

  // R9: collision held during lockout
  a_r9_col_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
    tx_disable |-> col);

  // R8: slow-speed off state
  a_r8_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    !speed_10 |=> (!col && !tx_disable));

  // R4: lockout only entered from a high transmit enable
  a_r4_entry_on_tx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_disable) |-> $past(tx_en));

  // R5: lockout only released on a low transmit enable
  a_r5_release_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_disable) && $past(speed_10)) |-> !$past(tx_en));
endmodule

bind sqe_jabber_ctrl sqe_jabber_ctrl_chk u_chk (.*);

// File: tb/sqe_jabber_ctrl_bench.sv
`timescale 1ns/1ps
module sqe_jabber_ctrl_bench;
  localparam int JAB = 20;
  localparam int REL = 40;
  localparam int GAP = 3;
  localparam int WID = 4;
  localparam real CLK_NS = 8.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic speed_10 = 1'b1;
  logic tx_en = 1'b0;
  logic col, tx_disable, jabber;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_NS / 2.0) clk = ~clk;

  sqe_jabber_ctrl #(
    .JAB_LIMIT (JAB),
    .REL_LIMIT (REL),
    .SQE_DELAY (GAP),
    .SQE_WIDTH (WID)
  ) u_sqe_jabber_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .speed_10   (speed_10),
    .tx_en      (tx_en),
    .col        (col),
    .tx_disable (tx_disable),
    .jabber     (jabber)
  );

  // entry: {speed_10, tx_en, cycles[7:0], exp_col, exp_dis, req[3:0]}
  function automatic logic [15:0] mk(input logic s, input logic t, input int n,
                                     input logic c, input logic d, input int r);
    return {s, t, 8'(n), c, d, 4'(r)};
  endfunction

  localparam int NV = 30;
  localparam logic [15:0] TBL [NV] = '{
    mk(1,1, 5,0,0, 3),   // R3 short frame
    mk(1,0, 3,0,0, 2),   // R2 still inside the gap
    mk(1,0, 1,1,0, 2),   // R2 pulse starts
    mk(1,0, 3,1,0, 2),   // R2 last pulse cycle
    mk(1,0, 1,0,0, 2),   // R2 pulse over
    mk(1,1,20,0,0, 3),   // R3 exactly at limit
    mk(1,1, 1,1,1, 4),   // R4 one more trips
    mk(1,1,10,1,1, 4),   // R4 stays locked
    mk(1,0,40,1,1, 5),   // R5 not released yet
    mk(1,0, 1,0,0, 5),   // R5 released
    mk(1,0, 8,0,0, 7),   // R7 no heartbeat after lockout
    mk(1,1,21,1,1, 4),   // R4 trip again
    mk(1,0,30,1,1, 6),   // R6 partway through release
    mk(1,1, 1,1,1, 6),   // R6 high sample restarts
    mk(1,0,40,1,1, 6),   // R6 restarted count not done
    mk(1,0, 1,0,0, 6),   // R6 release after full window
    mk(1,0, 6,0,0, 7),   // R7 still no heartbeat
    mk(0,1,30,0,0, 8),   // R8 no lockout at 100 Mb/s
    mk(0,0, 8,0,0, 8),   // R8 no heartbeat at 100 Mb/s
    mk(1,1,20,0,0, 8),   // R8 counter started from zero
    mk(1,1, 1,1,1, 4),   // R4 trip
    mk(0,1, 1,0,0, 8),   // R8 speed drop clears lockout
    mk(1,0,10,0,0, 8),   // R8 nothing carried over
    mk(1,1, 4,0,0, 2),   // R2 first frame
    mk(1,0, 2,0,0,10),   // R10 gap running
    mk(1,1, 1,0,0,10),   // R10 second short frame
    mk(1,0, 3,0,0,10),   // R10 gap restarted
    mk(1,0, 1,1,0,10),   // R10 pulse from second end
    mk(1,0, 3,1,0,10),   // R10 pulse held
    mk(1,0, 1,0,0,10)    // R10 pulse over
  };

  task automatic chk(input int req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic run(input logic s, input logic t, input int n);
    speed_10 = s;
    tx_en    = t;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 60000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, col, 1'b0, "col in reset");
    chk(1, tx_disable, 1'b0, "tx_disable in reset");
    chk(1, jabber, 1'b0, "jabber in reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] e;
      e = TBL[i];
      run(e[15], e[14], int'(e[13:6]));
      chk(int'(e[3:0]), col, e[5], $sformatf("col row %0d", i));
      chk(int'(e[3:0]), tx_disable, e[4], $sformatf("tx_disable row %0d", i));
      chk(9, jabber, e[4], $sformatf("jabber row %0d (R9)", i));
    end

    // R2 single-cycle frame still earns a pulse
    run(1, 1, 1);
    run(1, 0, GAP);
    chk(2, col, 1'b0, "one-cycle frame gap");
    run(1, 0, 1);
    chk(2, col, 1'b1, "one-cycle frame pulse");
    run(1, 0, WID);
    chk(2, col, 1'b0, "one-cycle frame pulse end");

    // R1 reset drops an active lockout
    run(1, 1, JAB + 1);
    chk(4, tx_disable, 1'b1, "lock before reset");
    rst_n = 1'b0;
    run(1, 0, 2);
    chk(1, tx_disable, 1'b0, "lock cleared by reset");
    chk(1, col, 1'b0, "col cleared by reset");
    rst_n = 1'b1;
    run(1, 0, GAP + WID + 2);
    chk(1, col, 1'b0, "no pulse after reset");

    finish_run();
  end
endmodule